// File: doc/BRIEF.md
# Three-Phase Gate Interlock and Dead-Time Guard

This block sits between a motor-control PWM generator and the gate drivers of a three-phase bridge. For each phase it takes a high-side request (active high) and a low-side request (active low) and produces a high-side and a low-side gate enable. The two enables of a phase never overlap. A request pattern that asks for both switches at once is treated as an interlock, and both gates are released. At every handover from one switch to the other, the block enforces a minimum off interval of `DEAD_CYC` clock cycles. The nominal 600 ns at 250 MHz is 150 cycles.

Two conditions override every phase. The first is a synchronous active-low shutdown level, which releases all gates on the next clock edge. The second is an undervoltage-ok flag from an external comparator. While that flag is low, all gates are held off. After it returns high, a phase stays off until its commands have passed through the idle pattern once, so a command that was stale while the flag was low cannot switch a gate on. The command inputs and the undervoltage flag are asynchronous and pass through a two-flop synchronizer. One per-phase controller is instantiated for each phase.

Top module: `tri_phase_gate_guard`

## Requirements
- R1: After reset, every high-side and low-side gate output is low.
- R2: While `shut_n` is sampled low, all gate outputs are low on the next cycle, whatever the commands. After `shut_n` returns high, a phase whose request matches the gate it last drove turns that gate back on one cycle later.
- R3: A phase with high request 1 and low request input 0 (both asserted) drives both of its gates low. This is the interlock state.
- R4: After a three-cycle latency from the command pins, a phase drives its gates as follows. High 1 with low input 1 gives the high gate only. High 0 with low input 0 gives the low gate only. High 0 with low input 1 gives both gates low.
- R5: When a phase hands over from one gate to the other, the new gate rises exactly `DEAD_CYC` cycles after the old gate falls.
- R6: When `uv_ok` is sampled low, all gates are low three cycles later.
- R7: After `uv_ok` returns high, a phase keeps both gates low until its commands have shown the idle pattern (high 0, low input 1). From then on it follows its commands again.
- R8: If one request releases and the opposite request asserts within the dead-time window, including through a short interlock overlap, both gates stay low until the window measured from the falling gate expires.
- R9: If both gates have already been off for at least `DEAD_CYC` cycles, a newly requested gate turns on with only the three-cycle command latency.
- R10: A phase whose high and low inputs are tied to one signal switches between its gates with plain dead-time behaviour.
- R11: The high and low gates of a phase are never both high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | NPH | High-side request per phase, active high, asynchronous |
| lo_cmd_n | input | NPH | Low-side request per phase, active low, asynchronous |
| shut_n | input | 1 | Shutdown level, active low, synchronous to clk |
| uv_ok | input | 1 | Supply-healthy flag from the undervoltage comparator, asynchronous |
| hi_gate | output | NPH | High-side gate enable per phase |
| lo_gate | output | NPH | Low-side gate enable per phase |

## Verification
The bench samples exactly the last cycle of each dead-time window and the first cycle after it. A counter that is off by one in either direction therefore shows up either as a gate rising one cycle early or as a gate still low one cycle too late.

It runs a long interlock followed by a release, which catches a design that adds a second, unnecessary dead time. It runs a short interlock overlap that falls inside the window, which catches a design that restarts the window from the late edge or lets the new gate through early.

It holds an active command while the undervoltage flag recovers. A design that lacks the idle re-arm would switch a gate on straight away. It asserts shutdown and then releases it, which exposes a design that fails to resume or resumes through a spurious dead time.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

  // Per-phase gate state; bit 0 is the high gate, bit 1 the low gate.
  typedef enum logic [1:0] {
    G_OFF = 2'b00,
    G_HI  = 2'b01,
    G_LO  = 2'b10
  } gate_e;

  // Map a synchronized command pair onto the requested gate.
  function automatic gate_e decode_cmd(input logic hi, input logic lo_n);
    case ({hi, lo_n})
      2'b11:   decode_cmd = G_HI;
      2'b00:   decode_cmd = G_LO;
      default: decode_cmd = G_OFF;  // idle or interlock
    endcase
  endfunction

endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/gg_phase.sv
module gg_phase
  import gate_guard_pkg::*;
#(
  parameter int DEAD_CYC = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_s,
  input  logic lo_n_s,
  input  logic uv_s,
  input  logic shut_n,
  output logic hi_gate,
  output logic lo_gate
);

  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DT_LOAD = DW'(DEAD_CYC);
  localparam logic [DW-1:0] DT_LAST = DW'(1);

  gate_e          req;
  gate_e          eff;
  gate_e          gate_q;
  gate_e          last_q;
  logic [DW-1:0]  dt_left_q;
  logic           armed_q;
  logic           idle_seen;
  logic           may_enter;

  assign req       = decode_cmd(hi_s, lo_n_s);
  assign idle_seen = !hi_s && lo_n_s;
  assign eff       = (armed_q && uv_s && shut_n) ? req : G_OFF;
  // Same side as last time needs no dead time; otherwise the window must end.
  assign may_enter = (eff == last_q) || (dt_left_q <= DT_LAST);

  // Re-arm only after an idle command while supply is healthy.
  always_ff @(posedge clk) begin
    if (rst)            armed_q <= 1'b0;
    else if (!uv_s)     armed_q <= 1'b0;
    else if (idle_seen) armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= G_OFF;
    end else if (gate_q != G_OFF) begin
      if (eff != gate_q) gate_q <= G_OFF;
    end else if (eff != G_OFF && may_enter) begin
      gate_q <= eff;
    end
  end

  // Window reloads while a gate conducts and runs down once both are off.
  always_ff @(posedge clk) begin
    if (rst)                   dt_left_q <= '0;
    else if (gate_q != G_OFF)  dt_left_q <= DT_LOAD;
    else if (dt_left_q != '0)  dt_left_q <= dt_left_q - DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                  last_q <= G_OFF;
    else if (gate_q != G_OFF) last_q <= gate_q;
  end

  assign hi_gate = gate_q[0];
  assign lo_gate = gate_q[1];

endmodule

// File: rtl/tri_phase_gate_guard.sv
module tri_phase_gate_guard #(
  parameter int NPH      = 3,
  parameter int DEAD_CYC = 150
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] hi_cmd,
  input  logic [NPH-1:0] lo_cmd_n,
  input  logic           shut_n,
  input  logic           uv_ok,
  output logic [NPH-1:0] hi_gate,
  output logic [NPH-1:0] lo_gate
);

  localparam int SW = 2 * NPH + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, {NPH{1'b1}}, {NPH{1'b0}}};

  logic [SW-1:0]  raw;
  logic [SW-1:0]  synced;
  logic [NPH-1:0] hi_s;
  logic [NPH-1:0] lo_n_s;
  logic           uv_s;

  assign raw = {uv_ok, lo_cmd_n, hi_cmd};

  gg_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  assign hi_s   = synced[NPH-1:0];
  assign lo_n_s = synced[2*NPH-1:NPH];
  assign uv_s   = synced[SW-1];

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    gg_phase #(.DEAD_CYC(DEAD_CYC)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .hi_s    (hi_s[p]),
      .lo_n_s  (lo_n_s[p]),
      .uv_s    (uv_s),
      .shut_n  (shut_n),
      .hi_gate (hi_gate[p]),
      .lo_gate (lo_gate[p])
    );
  end

endmodule

// File: rtl/gg_guard_chk.sv
module gg_guard_chk #(
  parameter int NPH      = 3,
  parameter int DEAD_CYC = 150
) (
  input logic           clk,
  input logic           rst,
  input logic           shut_n,
  input logic           uv_ok,
  input logic [NPH-1:0] hi_gate,
  input logic [NPH-1:0] lo_gate
);

  localparam int CW = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [CW-1:0] GAP = CW'(DEAD_CYC);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_gate & lo_gate) == '0);

  // R2
  shut_off_chk: assert property (@(posedge clk) disable iff (rst)
    !shut_n |=> (hi_gate == '0 && lo_gate == '0));

  // R6
  uv_off_chk: assert property (@(posedge clk) disable iff (rst)
    !uv_ok |-> ##3 (hi_gate == '0 && lo_gate == '0));

  for (genvar i = 0; i < NPH; i++) begin : g_gap
    logic [CW-1:0] off_run;
    logic          last_hi;
    logic          seen;

    always_ff @(posedge clk) begin
      if (rst) begin
        off_run <= '0;
        last_hi <= 1'b0;
        seen    <= 1'b0;
      end else if (hi_gate[i] || lo_gate[i]) begin
        off_run <= '0;
        last_hi <= hi_gate[i];
        seen    <= 1'b1;
      end else if (off_run < GAP) begin
        off_run <= off_run + CW'(1);
      end
    end

    // R5
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(lo_gate[i]) && seen && last_hi) |-> off_run >= GAP);

    // R5
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(hi_gate[i]) && seen && !last_hi) |-> off_run >= GAP);
  end

endmodule

bind tri_phase_gate_guard gg_guard_chk #(
  .NPH      (NPH),
  .DEAD_CYC (DEAD_CYC)
) u_gg_guard_chk (
  .clk     (clk),
  .rst     (rst),
  .shut_n  (shut_n),
  .uv_ok   (uv_ok),
  .hi_gate (hi_gate),
  .lo_gate (lo_gate)
);

// File: tb/tri_phase_gate_guard_bench.sv
`timescale 1ns/1ps
module tri_phase_gate_guard_bench;

  localparam int NPH = 3;
  localparam int DT  = 6;
  localparam int WD  = 20000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NPH-1:0] hi_cmd = '0;
  logic [NPH-1:0] lo_cmd_n = '1;
  logic           shut_n = 1'b1;
  logic           uv_ok = 1'b0;
  logic [NPH-1:0] hi_gate;
  logic [NPH-1:0] lo_gate;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int overlap_fails = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    int    ph;
    logic  hi;
    logic  lo;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t it;

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  tri_phase_gate_guard #(.NPH(NPH), .DEAD_CYC(DT)) u_tri_phase_gate_guard (
    .clk      (clk),
    .rst      (rst),
    .hi_cmd   (hi_cmd),
    .lo_cmd_n (lo_cmd_n),
    .shut_n   (shut_n),
    .uv_ok    (uv_ok),
    .hi_gate  (hi_gate),
    .lo_gate  (lo_gate)
  );

  // Driver side: queue an expected gate pair for a phase, off cycles from now.
  task automatic expect_at(int off, int ph, logic h, logic l, string tag);
    sb.push_back('{cyc + off, ph, h, l, tag});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare queued expectations in their cycle; R11 every cycle.
  always @(negedge clk) begin
    if (!rst && (hi_gate & lo_gate) != '0) begin
      overlap_fails++;
      fails++;
      $display("FAIL R11 cycle %0d: hi=%b lo=%b expected no common bit",
               cyc, hi_gate, lo_gate);
    end
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      tests++;
      if (it.at != cyc) begin
        fails++;
        $display("FAIL %s phase %0d: checked at cycle %0d, expected cycle %0d",
                 it.tag, it.ph, cyc, it.at);
      end else if (hi_gate[it.ph] !== it.hi || lo_gate[it.ph] !== it.lo) begin
        fails++;
        $display("FAIL %s phase %0d cycle %0d: hi/lo=%b%b expected %b%b",
                 it.tag, it.ph, cyc, hi_gate[it.ph], lo_gate[it.ph], it.hi, it.lo);
      end
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(5);
    rst = 1'b0;
    // R1: reset state
    for (int p = 0; p < NPH; p++) expect_at(1, p, 1'b0, 1'b0, "R1");
    step(2);

    // R6: supply flag low holds gates off despite high-side requests
    hi_cmd = 3'b111; lo_cmd_n = 3'b111;
    expect_at(3, 0, 1'b0, 1'b0, "R6");
    expect_at(6, 1, 1'b0, 1'b0, "R6");
    step(8);

    // R7: flag recovers with a stale active command: stays off
    uv_ok = 1'b1;
    expect_at(3, 0, 1'b0, 1'b0, "R7");
    expect_at(7, 2, 1'b0, 1'b0, "R7");
    step(8);

    // R7: idle pattern arms all phases; R4 idle gives both off
    hi_cmd = 3'b000;
    expect_at(3, 1, 1'b0, 1'b0, "R4");
    step(5);

    // R4: high request drives only high gate after three cycles
    hi_cmd = 3'b111;
    expect_at(2, 0, 1'b0, 1'b0, "R4");
    for (int p = 0; p < NPH; p++) expect_at(3, p, 1'b1, 1'b0, "R4");
    step(6);

    // R5: phase 0 hands over from high to low with exact dead time
    hi_cmd = 3'b110; lo_cmd_n = 3'b110;
    expect_at(3, 0, 1'b0, 1'b0, "R5");
    expect_at(2 + DT, 0, 1'b0, 1'b0, "R5");
    expect_at(3 + DT, 0, 1'b0, 1'b1, "R5");
    step(DT + 6);

    // R3: phase 1 both asserted for a long time: interlock
    lo_cmd_n = 3'b100;
    expect_at(3, 1, 1'b0, 1'b0, "R3");
    expect_at(6 + DT, 1, 1'b0, 1'b0, "R3");
    step(DT + 8);

    // R9: release after the window already expired: no added delay
    hi_cmd = 3'b100;
    expect_at(2, 1, 1'b0, 1'b0, "R9");
    expect_at(3, 1, 1'b0, 1'b1, "R9");
    step(5);

    // R8: phase 2 short overlap then low request inside the window
    lo_cmd_n = 3'b000;
    expect_at(3, 2, 1'b0, 1'b0, "R8");
    expect_at(2 + DT, 2, 1'b0, 1'b0, "R8");
    expect_at(3 + DT, 2, 1'b0, 1'b1, "R8");
    step(2);
    hi_cmd = 3'b000;
    step(DT + 4);

    // R10: phase 0 with tied inputs goes from low to high
    hi_cmd = 3'b001; lo_cmd_n = 3'b001;
    expect_at(3, 0, 1'b0, 1'b0, "R10");
    expect_at(2 + DT, 0, 1'b0, 1'b0, "R10");
    expect_at(3 + DT, 0, 1'b1, 1'b0, "R10");
    step(DT + 6);

    // R2: shutdown clears every phase next cycle
    shut_n = 1'b0;
    expect_at(1, 0, 1'b0, 1'b0, "R2");
    expect_at(1, 1, 1'b0, 1'b0, "R2");
    expect_at(3, 2, 1'b0, 1'b0, "R2");
    step(4);
    // R2: release resumes the same gates one cycle later
    shut_n = 1'b1;
    expect_at(1, 0, 1'b1, 1'b0, "R2");
    expect_at(1, 1, 1'b0, 1'b1, "R2");
    expect_at(1, 2, 1'b0, 1'b1, "R2");
    step(4);

    // R4: phase 0 returns to idle: both off
    hi_cmd = 3'b000;
    expect_at(3, 0, 1'b0, 1'b0, "R4");
    step(5);

    // R6: supply drop clears conducting low gates
    uv_ok = 1'b0;
    expect_at(3, 1, 1'b0, 1'b0, "R6");
    expect_at(3, 2, 1'b0, 1'b0, "R6");
    step(4);
    // R7: recovery with stale low requests stays off
    uv_ok = 1'b1;
    expect_at(5, 1, 1'b0, 1'b0, "R7");
    expect_at(5, 2, 1'b0, 1'b0, "R7");
    step(8);
    lo_cmd_n = 3'b011;  // phase 1 idle, phase 2 still low request
    step(4);
    lo_cmd_n = 3'b001;  // phase 1 low request again
    expect_at(3, 1, 1'b0, 1'b1, "R7");
    expect_at(3, 2, 1'b0, 1'b0, "R7");
    step(6);

    // R11: no overlap over the whole run
    tests++;
    if (overlap_fails != 0)
      $display("FAIL R11 summary: %0d overlap cycles, expected 0", overlap_fails);
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R4 scoreboard: %0d items left, expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule